// File: doc/BRIEF.md
# Predicated Element Issue Compactor

This block sits between instruction decode and an ALU that is several lanes wide. It accepts one vectorised operation: an element count, a predicate bitfield as wide as an integer register, and a zeroing flag. It breaks that operation into groups of scalar element operations and hands each group to the ALU. Each group carries the element index for every lane, a per-lane enable and a per-lane zero-write flag.

In normal mode, elements whose predicate bit is clear are skipped. The remaining elements are shifted down into consecutive lanes starting from lane 0, in ascending element order. Issue cycles are therefore spent only on live elements. After each accepted group, the issued elements are removed from the pending set and the remainder is scanned again. In zeroing mode, every element below the count is issued. Masked elements are flagged so that the ALU writes zero to them.

The operation is accepted through a start/ready handshake. Groups leave through a valid/ready handshake. A one-cycle done pulse marks the end of the operation.

Top module: `pred_issue_compactor`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `start_ready` is 1, `iss_valid` is 0 and `done` is 0.
- R2: With zeroing off, only elements i with i < `start_vl` and `start_mask[i]`=1 are issued. Mask bits at positions at or above `start_vl` have no effect. Each such element is issued exactly once.
- R3: A group fills lanes 0,1,2,… without gaps. `iss_lane_en` is a thermometer code that starts at bit 0, and lane k's element index sits in `iss_idx[k*IDXW +: IDXW]`. Indices rise strictly from lane to lane, and a group holds at most LANES elements.
- R4: Groups are issued in ascending element order, and every group except the last is full. With `iss_ready` held at 1, an operation with A elements to issue takes exactly ceil(A/LANES) issue cycles, one group per cycle.
- R5: While `iss_valid`=1 and `iss_ready`=0, the presented group (indices, enables, zero flags) stays unchanged on the next cycle, and no element is retired.
- R6: With zeroing on, every element 0..`start_vl`-1 is issued in order. `iss_lane_zero` is 1 exactly for elements whose mask bit is 0.
- R7: `done` is 1 for exactly one cycle, namely the cycle after the last group is accepted. `iss_valid` is 0 in that cycle, and `start_ready` returns to 1 on the next cycle.
- R8: When `start_vl`=0, or when zeroing is off and no mask bit below `start_vl` is set, `done` is 1 in the cycle right after the start is accepted and no group is ever issued.
- R9: While an operation is in progress, `start_ready` is 0 and `start_valid` is ignored: the ongoing issue sequence is unaffected.
- R10: The largest element count, `start_vl`=XLEN, is supported and covers every mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | A new operation is offered |
| start_ready | output | 1 | Block is idle and takes an operation |
| start_vl | input | VLW | Element count, 0..XLEN |
| start_mask | input | XLEN | Predicate bitfield, bit i for element i |
| start_zero | input | 1 | 1: issue masked elements as zero writes |
| iss_valid | output | 1 | A group is presented |
| iss_ready | input | 1 | ALU accepts the group this cycle |
| iss_idx | output | LANES*IDXW | Element index per lane, lane k at bits k*IDXW upward |
| iss_lane_en | output | LANES | Lane carries an element |
| iss_lane_zero | output | LANES | Lane's element is written as zero |
| done | output | 1 | One-cycle pulse: operation finished |

## Verification
The compaction path is driven with a sparse 8-element mask that needs one full group and one partial group, and with a dense full-width mask that needs eight full groups. Together these separate correct packing from simple element-by-element stepping. A mask with many bits set above the element count shows whether the count bound is applied. Zeroing mode over the same kind of mask shows whether masked elements are visited and flagged rather than dropped. An irregular ready pattern checks that stalled groups are held and nothing is lost. Empty operations and a start offered mid-operation cover the early-finish and busy paths.

// File: rtl/pred_issue_compactor.sv
module pred_issue_compactor #(
  parameter int XLEN  = 32,
  parameter int LANES = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start_valid,
  output logic                              start_ready,
  input  logic [$clog2(XLEN+1)-1:0]         start_vl,
  input  logic [XLEN-1:0]                   start_mask,
  input  logic                              start_zero,
  output logic                              iss_valid,
  input  logic                              iss_ready,
  output logic [LANES*$clog2(XLEN)-1:0]     iss_idx,
  output logic [LANES-1:0]                  iss_lane_en,
  output logic [LANES-1:0]                  iss_lane_zero,
  output logic                              done
);
  localparam int IDXW = $clog2(XLEN);
  localparam int VLW  = $clog2(XLEN + 1);

  logic            busy;
  logic [XLEN-1:0] pend;
  logic [XLEN-1:0] keep;
  logic [XLEN-1:0] vl_bound;
  logic [XLEN-1:0] taken;

  always_comb begin
    for (int i = 0; i < XLEN; i++) vl_bound[i] = (VLW'(i) < start_vl);
  end

  always_comb begin
    int cnt;
    cnt           = 0;
    taken         = '0;
    iss_idx       = '0;
    iss_lane_en   = '0;
    iss_lane_zero = '0;
    for (int i = 0; i < XLEN; i++) begin
      if (pend[i] && cnt < LANES) begin
        taken[i]                    = 1'b1;
        iss_idx[cnt*IDXW +: IDXW]   = IDXW'(i);
        iss_lane_en[cnt]            = 1'b1;
        iss_lane_zero[cnt]          = ~keep[i];
        cnt                         = cnt + 1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pend <= '0;
      keep <= '0;
    end else if (!busy) begin
      if (start_valid) begin
        busy <= 1'b1;
        pend <= start_zero ? vl_bound : (vl_bound & start_mask);
        keep <= start_zero ? start_mask : '1;
      end
    end else if (pend == '0) begin
      busy <= 1'b0;
    end else if (iss_ready) begin
      pend <= pend & ~taken;
    end
  end

  assign start_ready = ~busy;
  assign iss_valid   = busy & (|pend);
  assign done        = busy & ~(|pend);

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!iss_valid && !done && start_ready));

  a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_idx)
      && $stable(iss_lane_en) && $stable(iss_lane_zero)));

  a_r3_thermometer: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (iss_lane_en[0]
      && ((iss_lane_en & (iss_lane_en + LANES'(1))) == '0)));

  a_r9_busy_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid || done) |-> !start_ready);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && start_ready && !iss_valid));

  for (genvar k = 1; k < LANES; k++) begin : g_order
    a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_lane_en[k]) |->
        (iss_idx[k*IDXW +: IDXW] > iss_idx[(k-1)*IDXW +: IDXW]));
  end
endmodule

// File: tb/pred_issue_compactor_tb.sv
module pred_issue_compactor_tb;
  localparam int XLEN  = 32;
  localparam int LANES = 4;
  localparam int IDXW  = $clog2(XLEN);
  localparam int VLW   = $clog2(XLEN + 1);
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, start_valid, start_ready, start_zero, iss_valid, iss_ready, done;
  logic [VLW-1:0] start_vl;
  logic [XLEN-1:0] start_mask;
  logic [LANES*IDXW-1:0] iss_idx;
  logic [LANES-1:0] iss_lane_en, iss_lane_zero;

  int n_checks = 0;
  int n_fail = 0;
  int wd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pred_issue_compactor #(.XLEN(XLEN), .LANES(LANES)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_vl(start_vl), .start_mask(start_mask), .start_zero(start_zero),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_idx(iss_idx),
    .iss_lane_en(iss_lane_en), .iss_lane_zero(iss_lane_zero), .done(done));

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", wd, 100000);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // stall: 0 = ready always high, 1 = irregular ready pattern
  task automatic run_op(input string req, input int vl, input logic [XLEN-1:0] mask,
                        input bit zm, input int stall, input bit poke);
    int exp_idx[XLEN];
    bit exp_z[XLEN];
    int n = 0;
    int ptr = 0;
    int grp = 0;
    int cyc = 0;
    int exp_groups;
    bit fin = 0;
    bit held = 0;
    logic [LANES*IDXW-1:0] s_idx;
    logic [LANES-1:0] s_en, s_z;
    for (int i = 0; i < vl; i++) begin
      if (zm || mask[i]) begin
        exp_idx[n] = i;
        exp_z[n] = ~mask[i];
        n++;
      end
    end
    exp_groups = (n + LANES - 1) / LANES;
    @(negedge clk);
    chk(start_ready == 1'b1, req, "start_ready before start", start_ready, 1);
    start_valid = 1'b1;
    start_vl = VLW'(vl);
    start_mask = mask;
    start_zero = zm;
    @(negedge clk);
    start_valid = 1'b0;
    while (!fin && cyc < 500) begin
      iss_ready = (stall == 0) ? 1'b1 : ((cyc % 3) != 1);
      if (poke && cyc == 1) begin
        start_valid = 1'b1;
        start_mask = ~mask;
        start_vl = VLW'(XLEN);
        start_zero = 1'b1;
      end else start_valid = 1'b0;
      #1;
      if (done) begin
        chk(ptr == n, req, "elements issued before done", ptr, n);
        chk(iss_valid == 1'b0, "R7", "iss_valid with done", iss_valid, 0);
        if (n == 0) chk(cyc == 0, "R8", "cycles to done when empty", cyc, 0);
        fin = 1;
      end else if (iss_valid) begin
        if (poke && cyc == 1)
          chk(start_ready == 1'b0, "R9", "start_ready while busy", start_ready, 0);
        if (held) begin
          chk(iss_idx == s_idx && iss_lane_en == s_en && iss_lane_zero == s_z,
              "R5", "group held during stall", iss_idx, s_idx);
          held = 0;
        end
        if (iss_ready) begin
          for (int l = 0; l < LANES; l++) begin
            bit en = (ptr + l) < n;
            chk(iss_lane_en[l] == en, "R3", "lane enable", iss_lane_en[l], en);
            if (en && iss_lane_en[l]) begin
              chk(int'(iss_idx[l*IDXW +: IDXW]) == exp_idx[ptr+l], req, "lane index",
                  iss_idx[l*IDXW +: IDXW], exp_idx[ptr+l]);
              chk(iss_lane_zero[l] == exp_z[ptr+l], zm ? "R6" : "R2", "zero flag",
                  iss_lane_zero[l], exp_z[ptr+l]);
            end
          end
          ptr += ((n - ptr) < LANES) ? (n - ptr) : LANES;
          grp++;
        end else begin
          s_idx = iss_idx;
          s_en = iss_lane_en;
          s_z = iss_lane_zero;
          held = 1;
        end
      end else begin
        chk(0, req, "neither valid nor done while busy", 0, 1);
        fin = 1;
      end
      if (!fin) begin
        @(negedge clk);
        cyc++;
      end
    end
    start_valid = 1'b0;
    iss_ready = 1'b0;
    chk(fin, req, "operation finished", fin, 1);
    chk(grp == exp_groups, "R4", "group count", grp, exp_groups);
    if (stall == 0) chk(cyc == exp_groups, "R4", "issue cycles", cyc, exp_groups);
    @(negedge clk);
    #1;
    chk(done == 1'b0 && start_ready == 1'b1, "R7", "idle after done pulse",
        {done, start_ready}, 1);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    start_valid = 1'b0;
    start_vl = '0;
    start_mask = '0;
    start_zero = 1'b0;
    iss_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(start_ready == 1'b1 && iss_valid == 1'b0 && done == 1'b0, "R1",
        "idle outputs in reset", {start_ready, iss_valid, done}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(start_ready == 1'b1 && iss_valid == 1'b0 && done == 1'b0, "R1",
        "idle outputs after reset", {start_ready, iss_valid, done}, 3'b100);
  endtask

  initial begin
    test_reset();
    run_op("R2", 8, 32'h0000_00BB, 1'b0, 0, 1'b0);
    run_op("R2", 8, 32'hFFFF_FF05, 1'b0, 0, 1'b0);
    run_op("R10", XLEN, 32'hFFFF_FFFF, 1'b0, 0, 1'b0);
    run_op("R5", 20, 32'h000F_5A6D, 1'b0, 1, 1'b0);
    run_op("R6", 6, 32'h0000_0005, 1'b1, 0, 1'b0);
    run_op("R6", 11, 32'h0000_0481, 1'b1, 1, 1'b0);
    run_op("R8", 0, 32'hFFFF_FFFF, 1'b0, 0, 1'b0);
    run_op("R8", 10, 32'hFFFF_FC00, 1'b0, 0, 1'b0);
    run_op("R9", 16, 32'h0000_F0F3, 1'b0, 0, 1'b1);
    run_op("R10", XLEN, 32'h8000_0001, 1'b0, 0, 1'b0);
    finish_run();
  end
endmodule